// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block sits on the inbound side of a PCI host bridge. It turns an address issued by a PCI bus master into a system memory address. Each incoming address is checked against a small set of programmable target windows. A window is defined by a base, a size mask, a translation base and a mode bit.

A direct window replaces the upper address bits with the translation base. A scatter-gather window treats the address inside the window as a page number and an in-page offset. The page number indexes a page table held in system memory. Page table entries are cached in a small fully associative translation buffer, and a miss fetches the entry through a read request/response port.

Requests enter on a valid/ready stream and results leave on a valid/ready stream. The block translates one request at a time. `req_ready` is high only while the block is idle. A result is held with its flags unchanged until `res_ready` is seen high. Page-table reads use `mrd_valid`/`mrd_ready`, and `mrd_valid` stays high with a stable address until it is accepted. Read data on `mdat_valid` has no back-pressure. It is only taken while a fetch is outstanding. Configuration uses a plain single-cycle write strobe.

Top module: `dma_win_xlate`

## Requirements
- R1: Each window has three registers, selected by `csr_addr = {0, window[1:0], sel[1:0]}`.
  - sel 0 (control) holds the enable in bit 0, scatter-gather mode in bit 1 and the window base in bits 31:20.
  - sel 1 holds the size mask in bits 31:20.
  - sel 2 holds the 32-bit translation or table base.
  - A window claims an address when it is enabled and `(addr[31:20] & ~mask) == (base & ~mask)`. A zero mask therefore gives a 1MB window.
- R2: When several windows claim an address, the lowest-numbered one is used. When none does, the result has `res_hit=0`, `res_err=0` and `res_addr=0`.
- R3: For a direct window, `res_addr` is `(tbase & ~ext) | (addr & ext)` zero-extended to 33 bits, where `ext = {mask, 20'hFFFFF}`.
- R4: For a scatter-gather window, the entry address is `tbase + (((addr & ext) >> 13) << 3)`. This is the address presented on `mrd_addr`.
- R5: On a scatter-gather translation with a valid entry, `res_addr = {pte[20:1], addr[12:0]}`.
- R6: A buffer miss issues exactly one memory read, fills the buffer and completes the translation. A later access to the same page hits and issues no read.
- R7: An entry read with bit 0 clear gives `res_hit=1`, `res_err=1` and `res_addr=0`. The entry is not cached, so repeating the access reads memory again.
- R8: The 8-entry buffer is filled in round-robin order starting from entry 0. The ninth distinct fill evicts the first page and keeps the second.
- R9: A write to the invalidate register (`csr_addr` bit 4 set) empties the buffer and returns the fill pointer to entry 0.
- R10: Any write to a window's control, mask or base register also empties the buffer.
- R11: The handshake rules are these.
  - `req_ready` is low while a translation is in flight.
  - The result stays valid and stable while `res_ready` is low.
  - `mrd_valid` and `mrd_addr` stay stable until `mrd_ready`.
- R12: After reset, `req_ready=1`, `res_valid=0`, `mrd_valid=0`, and every window is disabled, so no address is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Configuration write strobe |
| csr_addr | input | 5 | Configuration register select |
| csr_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Inbound address valid |
| req_ready | output | 1 | Block can accept an address |
| req_addr | input | 32 | PCI address to translate |
| res_valid | output | 1 | Translation result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 33 | System physical address |
| res_hit | output | 1 | A window claimed the address |
| res_err | output | 1 | Page table entry was invalid |
| mrd_valid | output | 1 | Page-table read request |
| mrd_ready | input | 1 | Memory accepts the read |
| mrd_addr | output | 32 | Page-table entry address |
| mdat_valid | input | 1 | Read data valid |
| mdat_data | input | 32 | Page table entry |

## Verification
Overlapping windows are configured so that the same address pattern separates priority, mask comparison and window edges:
- Addresses are placed just inside and just outside each window.
- Addresses fall where a small window sits inside a larger one.
- Some addresses lie in no window at all.

Scatter-gather traffic mixes several kinds of access:
- repeated pages, which show whether a hit avoided a memory read;
- fresh pages, which show that a miss made exactly one read;
- entries whose valid bit is clear, which show that errors are raised and not cached.

A run of nine distinct pages after an invalidate distinguishes true round-robin eviction from other replacement orders. Stalls on both the read port and the result port show whether values are held stable under back-pressure.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  localparam int PCI_AW    = 32;
  localparam int WIN_LSB   = 20;
  localparam int WIN_BITS  = PCI_AW - WIN_LSB;
  localparam int PAGE_OFF  = 13;
  localparam int PFN_W     = 20;
  localparam int SYS_AW    = PFN_W + PAGE_OFF;
  localparam int PTE_SHIFT = 3;
  localparam int TAG_W     = PCI_AW - PTE_SHIFT;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_MASK  = 2'd1;
  localparam logic [1:0] SEL_TBASE = 2'd2;

  typedef struct packed {
    logic                en;
    logic                sg;
    logic [WIN_BITS-1:0] base;
    logic [WIN_BITS-1:0] mask;
    logic [PCI_AW-1:0]   tbase;
  } win_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_FETCH, ST_WAIT, ST_DONE
  } xl_state_t;
endpackage

// File: rtl/dwt_csr.sv
module dwt_csr
  import dwt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CA_W   = WIN_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    csr_we,
  input  logic [CA_W-1:0]         csr_addr,
  input  logic [31:0]             csr_wdata,
  output win_cfg_t [NUM_WIN-1:0]  cfg,
  output logic                    flush
);
  logic             is_inval;
  logic [WIN_W-1:0] wsel;
  logic [1:0]       rsel;

  assign is_inval = csr_addr[CA_W-1];
  assign wsel     = csr_addr[WIN_W+1:2];
  assign rsel     = csr_addr[1:0];

  // any write to the invalidate register or a live window register empties the buffer
  assign flush = csr_we && (is_inval || rsel != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (csr_we && !is_inval) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (wsel == WIN_W'(i)) begin
          case (rsel)
            SEL_CTRL: begin
              cfg[i].en   <= csr_wdata[0];
              cfg[i].sg   <= csr_wdata[1];
              cfg[i].base <= csr_wdata[PCI_AW-1:WIN_LSB];
            end
            SEL_MASK:  cfg[i].mask  <= csr_wdata[PCI_AW-1:WIN_LSB];
            SEL_TBASE: cfg[i].tbase <= csr_wdata;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dwt_win_match.sv
module dwt_win_match
  import dwt_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic [PCI_AW-1:0]       addr,
  input  win_cfg_t [NUM_WIN-1:0]  cfg,
  output logic                    hit,
  output win_cfg_t                sel_cfg
);
  logic [NUM_WIN-1:0] match;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign match[g] = cfg[g].en &&
      ((addr[PCI_AW-1:WIN_LSB] & ~cfg[g].mask) == (cfg[g].base & ~cfg[g].mask));
  end

  // scan from the top so the lowest-numbered matching window is left selected
  always_comb begin
    hit     = 1'b0;
    sel_cfg = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        sel_cfg = cfg[i];
      end
    end
  end
endmodule

// File: rtl/dwt_tlb.sv
module dwt_tlb
  import dwt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TW    = TAG_W,
  parameter int DW    = PFN_W,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [TW-1:0] lk_tag,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  input  logic          fill_en,
  input  logic [TW-1:0] fill_tag,
  input  logic [DW-1:0] fill_data
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] hit_vec;
  logic [TW-1:0]    tag_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];
  logic [PW-1:0]    ptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cam
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) lk_data = lk_data | dat_q[i];
    end
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (fill_en) begin
      vld_q[ptr_q] <= 1'b1;
      tag_q[ptr_q] <= fill_tag;
      dat_q[ptr_q] <= fill_data;
      ptr_q        <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
  assert_fill_marks_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> vld_q[$past(ptr_q)]);
endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate
  import dwt_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int TLB_DEPTH = 8,
  localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CA_W     = WIN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CA_W-1:0]   csr_addr,
  input  logic [31:0]       csr_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PCI_AW-1:0] req_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [SYS_AW-1:0] res_addr,
  output logic              res_hit,
  output logic              res_err,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [PCI_AW-1:0] mrd_addr,
  input  logic              mdat_valid,
  input  logic [31:0]       mdat_data
);
  win_cfg_t [NUM_WIN-1:0] cfg;
  win_cfg_t               sel_cfg;
  logic                   flush, win_hit, tlb_hit, fill_en;
  logic [PFN_W-1:0]       tlb_data;
  xl_state_t              st_q;
  logic [PCI_AW-1:0]      addr_q, pte_q;
  logic                   stale_q;
  logic [PCI_AW-1:0]      ext, in_win, pte_addr;
  logic [SYS_AW-1:0]      direct_addr;

  dwt_csr #(.NUM_WIN(NUM_WIN)) u_csr (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .cfg, .flush
  );

  dwt_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr(addr_q), .cfg, .hit(win_hit), .sel_cfg
  );

  // address formation for the selected window
  assign ext         = {sel_cfg.mask, {WIN_LSB{1'b1}}};
  assign in_win      = addr_q & ext;
  assign direct_addr = SYS_AW'((sel_cfg.tbase & ~ext) | in_win);
  assign pte_addr    = sel_cfg.tbase + ((in_win >> PAGE_OFF) << PTE_SHIFT);

  dwt_tlb #(.DEPTH(TLB_DEPTH), .TW(TAG_W), .DW(PFN_W)) u_tlb (
    .clk, .rst_n, .flush,
    .lk_tag(pte_addr[PCI_AW-1:PTE_SHIFT]), .lk_hit(tlb_hit), .lk_data(tlb_data),
    .fill_en, .fill_tag(pte_q[PCI_AW-1:PTE_SHIFT]), .fill_data(mdat_data[PFN_W:1])
  );

  // an invalidate seen during a fetch keeps the fetched entry out of the buffer
  assign fill_en = (st_q == ST_WAIT) && mdat_valid && mdat_data[0] && !stale_q && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      pte_q    <= '0;
      stale_q  <= 1'b0;
      res_addr <= '0;
      res_hit  <= 1'b0;
      res_err  <= 1'b0;
    end else begin
      if (flush && st_q != ST_IDLE) stale_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          stale_q <= 1'b0;
          st_q    <= ST_LOOK;
        end
        ST_LOOK: begin
          res_hit <= win_hit;
          res_err <= 1'b0;
          pte_q   <= pte_addr;
          if (!win_hit) begin
            res_addr <= '0;
            st_q     <= ST_DONE;
          end else if (!sel_cfg.sg) begin
            res_addr <= direct_addr;
            st_q     <= ST_DONE;
          end else if (tlb_hit) begin
            res_addr <= {tlb_data, addr_q[PAGE_OFF-1:0]};
            st_q     <= ST_DONE;
          end else begin
            st_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (mrd_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mdat_valid) begin
          if (mdat_data[0]) begin
            res_addr <= {mdat_data[PFN_W:1], addr_q[PAGE_OFF-1:0]};
            res_err  <= 1'b0;
          end else begin
            res_addr <= '0;
            res_err  <= 1'b1;
          end
          st_q <= ST_DONE;
        end
        ST_DONE: if (res_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign res_valid = (st_q == ST_DONE);
  assign mrd_valid = (st_q == ST_FETCH);
  assign mrd_addr  = pte_q;

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_hit) && $stable(res_err)));
  assert_mrd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));
  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mrd_valid) |-> !req_ready);
  assert_err_claimed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_hit && res_addr == '0));
  assert_nohit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_addr == '0 && !res_err));
endmodule

// File: tb/test_dma_win_xlate.sv
module test_dma_win_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [4:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [32:0] res_addr;
  logic        res_hit, res_err;
  logic        mrd_valid;
  logic        mrd_ready = 1'b1;
  logic [31:0] mrd_addr;
  logic        mdat_valid = 1'b0;
  logic [31:0] mdat_data = '0;

  int nchk = 0, nerr = 0, nreads = 0, cyc = 0;

  dma_win_xlate i_dma_win_xlate (.*);

  always #2.5ns clk = ~clk;

  // bench copy of the window configuration
  logic        m_en [4];
  logic        m_sg [4];
  logic [11:0] m_base [4];
  logic [11:0] m_mask [4];
  logic [31:0] m_tb [4];

  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [19:0] pfn;
    pfn = a[22:3] ^ 20'h5A5A5;
    return {11'd0, pfn, (a[6:3] != 4'hF)};
  endfunction

  // {hit, err, addr[32:0]} from requirements R1..R5, R7
  function automatic logic [34:0] model(input logic [31:0] a);
    logic [31:0] ext, pa, pte;
    bit found;
    found = 0;
    model = '0;
    for (int i = 0; i < 4; i++) begin
      if (!found && m_en[i] && ((a[31:20] & ~m_mask[i]) == (m_base[i] & ~m_mask[i]))) begin
        found = 1;
        ext = {m_mask[i], 20'hFFFFF};
        if (!m_sg[i]) model = {3'b100, (m_tb[i] & ~ext) | (a & ext)};
        else begin
          pa  = m_tb[i] + (((a & ext) >> 13) << 3);
          pte = pte_of(pa);
          if (pte[0]) model = {2'b10, pte[20:1], a[12:0]};
          else        model = {2'b11, 33'd0};
        end
      end
    end
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: samples shortly after the falling edge
  int mem_cnt = 0;
  bit mem_pend = 0;
  logic [31:0] mem_a = '0;
  always @(negedge clk) begin
    #1ns;
    mdat_valid <= 1'b0;
    if (mem_pend) begin
      if (mem_cnt == 0) begin
        mdat_valid <= 1'b1;
        mdat_data  <= pte_of(mem_a);
        mem_pend   <= 0;
      end else mem_cnt <= mem_cnt - 1;
    end else if (mrd_valid && mrd_ready) begin
      mem_pend <= 1;
      mem_a    <= mrd_addr;
      mem_cnt  <= 2;
      nreads   <= nreads + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic csr_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
    if (!a[4]) begin
      case (a[1:0])
        2'd0: begin m_en[a[3:2]] = d[0]; m_sg[a[3:2]] = d[1]; m_base[a[3:2]] = d[31:20]; end
        2'd1: m_mask[a[3:2]] = d[31:20];
        2'd2: m_tb[a[3:2]] = d;
        default: ;
      endcase
    end
  endtask

  task automatic xlate(input logic [31:0] a, input int exp_reads, input int mrd_hold,
                       input int res_hold, input string tag);
    int r0;
    logic [34:0] first;
    r0 = nreads;
    @(negedge clk);
    mrd_ready = (mrd_hold == 0);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (mrd_hold > 0) begin
      while (!mrd_valid) @(negedge clk);
      for (int k = 0; k < mrd_hold; k++) begin
        check({tag, " R4 held entry address"}, {31'd0, mrd_valid, mrd_addr},
              {31'd0, 1'b1, m_tb[1] + (((a & {m_mask[1], 20'hFFFFF}) >> 13) << 3)});
        @(negedge clk);
      end
      mrd_ready = 1'b1;
    end
    while (!res_valid) @(negedge clk);
    first = {res_hit, res_err, res_addr};
    for (int k = 0; k < res_hold; k++) begin
      @(negedge clk);
      check({tag, " R11 result held"}, {27'd0, req_ready, res_valid, res_hit, res_err, res_addr},
            {27'd0, 1'b0, 1'b1, first});
    end
    check({tag, " result"}, {29'd0, res_hit, res_err, res_addr}, {29'd0, model(a)});
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check({tag, " reads"}, 64'(nreads - r0), 64'(exp_reads));
  endtask

  localparam int NVEC = 16;
  localparam logic [39:0] VEC [NVEC] = '{
    {32'h1000_1234, 8'd0},  // R3 R2 win0 beats win2
    {32'h1050_0010, 8'd0},  // R1 win2 only
    {32'h1010_0000, 8'd0},  // R1 one past win0
    {32'h100F_FFFF, 8'd0},  // R1 top of win0
    {32'h3000_0000, 8'd0},  // R2 disabled window
    {32'h0FFF_FFFF, 8'd0},  // R2 below all windows
    {32'h1FFF_FFFF, 8'd0},  // R3 top of win2
    {32'h2000_2004, 8'd1},  // R6 miss
    {32'h2000_3FFF, 8'd0},  // R5 hit same page
    {32'h2000_0000, 8'd1},  // R6 miss
    {32'h2000_0008, 8'd0},  // R5 hit
    {32'h2001_E000, 8'd1},  // R7 invalid entry
    {32'h2001_E123, 8'd1},  // R7 not cached
    {32'h2080_0000, 8'd1},  // R4 high page
    {32'h20FF_FFFF, 8'd1},  // R7 last page, invalid
    {32'h2100_0000, 8'd0}   // R1 past win1
  };

  function automatic logic [31:0] pg(input int n);
    return 32'h2000_0000 + 32'(n) * 32'h2000;
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_en[i] = 0; m_sg[i] = 0; m_base[i] = '0; m_mask[i] = '0; m_tb[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R12 reset outputs", {61'd0, req_ready, res_valid, mrd_valid}, {61'd0, 3'b100});
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle after reset", {61'd0, req_ready, res_valid, mrd_valid}, {61'd0, 3'b100});
    xlate(32'h1000_0000, 0, 0, 0, "R12 windows off");

    csr_wr(5'h01, 32'h0000_0000); csr_wr(5'h02, 32'h4000_0000); csr_wr(5'h00, 32'h1000_0001);
    csr_wr(5'h05, 32'h00F0_0000); csr_wr(5'h06, 32'h0800_0000); csr_wr(5'h04, 32'h2000_0003);
    csr_wr(5'h09, 32'h0FF0_0000); csr_wr(5'h0A, 32'h8000_0000); csr_wr(5'h08, 32'h1000_0001);
    csr_wr(5'h0E, 32'hC000_0000); csr_wr(5'h0C, 32'h3000_0000);

    for (int v = 0; v < NVEC; v++)
      xlate(VEC[v][39:8], int'(VEC[v][7:0]), 0, 0, $sformatf("vec%0d R1-table", v));

    // R9: invalidate then refetch
    csr_wr(5'h10, 32'h0);
    xlate(pg(1), 1, 0, 0, "R9 refetch after invalidate");
    // R8: round robin
    for (int n = 2; n <= 8; n++) xlate(pg(n), 1, 0, 0, "R8 fill");
    xlate(pg(1), 0, 0, 0, "R8 full buffer hit");
    xlate(pg(9), 1, 0, 0, "R8 ninth fill");
    xlate(pg(2), 0, 0, 0, "R8 second kept");
    xlate(pg(1), 1, 0, 0, "R8 first evicted");
    xlate(pg(3), 0, 0, 0, "R8 third kept");
    xlate(pg(2), 1, 0, 0, "R8 second now evicted");
    // R10: rewrite of a mask register empties the buffer
    csr_wr(5'h05, 32'h00F0_0000);
    xlate(pg(3), 1, 0, 0, "R10 mask write flush");
    xlate(pg(3), 0, 0, 0, "R10 refilled");
    csr_wr(5'h0E, 32'hC000_0000);
    xlate(pg(3), 1, 0, 0, "R10 base write flush");
    // R11: back-pressure on both ports
    xlate(pg(32'h20), 1, 4, 3, "R11 stalls");
    xlate(32'h1000_0042, 0, 0, 3, "R11 direct stall");

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule